// File: doc/BRIEF.md
# Open-Drain Synchronous Bit Transceiver

This block moves one byte at a time across a three-wire slave bus: a master-driven bit clock, a shared open-drain data line, and a bus-enable line. The same byte-wide shift register feeds the outgoing bits and collects the incoming ones. Transmit and receive therefore happen together. When a byte finishes, the register holds whatever was seen on the wire.

The line uses inverted signalling. To send a one, the block asserts its pull-low enable. To send a zero, it releases the line. On receive, a low line reads as one and a high line reads as zero. The asynchronous bus inputs pass through two-flop synchronizers, and bit-clock edges are found on the synchronized copy. A transmit byte is loaded through a parallel port while the block sits between bytes. A one-cycle strobe reports each completed byte together with the received value. If bus-enable drops before the byte completes, the byte is abandoned without a strobe.

Top module: `od_bit_xcvr`

## Requirements
- R1: After reset, `dat_pull_o` and `byte_done_o` are both 0.
- R2: On each rising bit-clock edge while enabled, `dat_pull_o` shows the next transmit bit, most significant bit first. A 1 bit sets it to 1 (line pulled low) and a 0 bit sets it to 0 (line released). It does not change except on a rising edge, on byte completion, or on abort.
- R3: On each falling bit-clock edge while enabled, the line level is captured inverted: a low line gives 1 and a high line gives 0.
- R4: Each captured bit enters bit 0 of the shared register as its contents shift toward bit 7. After eight bits, `rx_byte_o` equals the eight captured bits, first captured in bit 7.
- R5: `byte_done_o` pulses high for exactly one system clock after the eighth falling edge, with no wait for another rising edge, and `rx_byte_o` carries the received byte in that cycle.
- R6: If bus-enable is low while the block waits for either bit-clock edge, the byte is abandoned. No strobe is raised, `dat_pull_o` returns to 0, and the bit count restarts, so the next byte again takes eight bits.
- R7: `load_i` with `load_byte_i` is taken only while idle between bytes. A load during a byte changes neither the bits sent nor the byte received.
- R8: Bit-clock edges while bus-enable is low start no byte: `dat_pull_o` stays 0 and no strobe is raised.
- R9: Without a new load, the next byte transmits the byte received last.
- R10: After a byte completes, `dat_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Master bit clock, asynchronous |
| bus_dat_i | input | 1 | Open-drain data line level, asynchronous |
| bus_en_i | input | 1 | Bus-enable line, asynchronous |
| dat_pull_o | output | 1 | 1 pulls the data line low |
| load_i | input | 1 | Load request for the transmit byte |
| load_byte_i | input | 8 | Byte to transmit |
| byte_done_o | output | 1 | One-cycle strobe: byte complete |
| rx_byte_o | output | 8 | Received byte, valid with the strobe |

## Verification
Every bus input passes through two synchronizer stages before the engine registers it. A rising bit-clock edge therefore shows on `dat_pull_o` at the third system clock after the change, and a falling edge raises `byte_done_o` at the third clock after the change. Aborts take effect on the same third clock after bus-enable drops. The bench holds each bit-clock half period for six system clocks and checks outputs only at the end of that window, after the result has settled. A monitor samples the strobe on every falling system clock edge, so it counts each pulse and catches a strobe more than one cycle wide.

// File: rtl/od_xcvr_pkg.sv
package od_xcvr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_FALL = 2'd1,
    ST_WAIT_RISE = 2'd2
  } xcvr_state_e;
endpackage

// File: rtl/od_sync.sv
module od_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/od_edge.sv
module od_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/od_shift_eng.sv
module od_shift_eng
  import od_xcvr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              en_i,
  input  logic              dat_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              pull_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] sr_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  xcvr_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              oe_q;
  logic              done_q;
  logic [BYTE_W-1:0] idle_sr;

  // a load in the same cycle as a start edge supplies the first bit
  assign idle_sr = load_i ? load_byte_i : sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sr_q <= idle_sr;
          if (rise_i && en_i) begin
            oe_q    <= idle_sr[BYTE_W-1];
            state_q <= ST_WAIT_FALL;
          end
        end
        ST_WAIT_FALL: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
          end else if (fall_i) begin
            sr_q <= {sr_q[BYTE_W-2:0], ~dat_i};
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              oe_q    <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_WAIT_RISE;
            end
          end
        end
        ST_WAIT_RISE: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
          end else if (rise_i) begin
            oe_q    <= sr_q[BYTE_W-1];
            state_q <= ST_WAIT_FALL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pull_o = oe_q;
  assign done_o = done_q;
  assign sr_o   = sr_q;

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(fall_i && en_i));
  p_abort_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!oe_q && !done_q));
  p_pull_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i && !fall_i && en_i) |=> $stable(oe_q));
endmodule

// File: rtl/od_bit_xcvr.sv
module od_bit_xcvr #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic              bus_en_i,
  output logic              dat_pull_o,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  logic [2:0] sync_s;
  logic       clk_s, dat_s, en_s;
  logic       rise_s, fall_s;

  od_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({bus_en_i, bus_dat_i, bus_clk_i}),
    .sync_o  (sync_s)
  );

  assign clk_s = sync_s[0];
  assign dat_s = sync_s[1];
  assign en_s  = sync_s[2];

  od_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (clk_s),
    .rise_o (rise_s),
    .fall_o (fall_s)
  );

  od_shift_eng #(.BYTE_W(BYTE_W)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise_s),
    .fall_i      (fall_s),
    .en_i        (en_s),
    .dat_i       (dat_s),
    .load_i      (load_i),
    .load_byte_i (load_byte_i),
    .pull_o      (dat_pull_o),
    .done_o      (byte_done_o),
    .sr_o        (rx_byte_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!dat_pull_o && !byte_done_o));
endmodule

// File: tb/od_bit_xcvr_tb_top.sv
module od_bit_xcvr_tb_top;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0;
  logic       bus_en = 1'b0;
  logic       peer_pull = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_byte = '0;
  logic       pull, done;
  logic [7:0] rx_byte;
  logic       bus_dat;

  int total = 0, bad = 0;
  int done_cnt = 0;
  logic [7:0] rx_last = '0;
  logic prev_done = 1'b0;
  int wide_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // wired line: low if either side pulls
  assign bus_dat = ~(pull | peer_pull);

  od_bit_xcvr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bus_clk), .bus_dat_i(bus_dat),
    .bus_en_i(bus_en), .dat_pull_o(pull), .load_i(load), .load_byte_i(load_byte),
    .byte_done_o(done), .rx_byte_o(rx_byte)
  );

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      rx_last = rx_byte;
      if (prev_done) wide_err++;
    end
    prev_done = done;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [7:0] b);
    @(negedge clk);
    load = 1'b1; load_byte = b;
    @(negedge clk);
    load = 1'b0;
  endtask

  // one bit: rise, check pull, fall
  task automatic one_bit(input logic exp_pull, input logic peer, input string req);
    peer_pull = peer;
    bus_clk = 1'b1;
    wait_n(HALF);
    chk(req, pull, exp_pull);
    bus_clk = 1'b0;
    wait_n(HALF);
  endtask

  task automatic run_byte(input logic [7:0] tx, input logic [7:0] peer, input string req);
    int d0 = done_cnt;
    for (int i = 7; i >= 0; i--) begin
      one_bit(tx[i], peer[i], req);
      if (i != 0) chk("R5 no early done", done_cnt, d0);
    end
    peer_pull = 1'b0;
    chk("R5 done after 8th fall", done_cnt, d0 + 1);
    chk("R4 rx byte", rx_last, tx | peer);
    chk("R10 released after byte", pull, 0);
  endtask

  task automatic t_reset();
    wait_n(2);
    chk("R1 pull after reset", pull, 0);
    chk("R1 done after reset", done, 0);
  endtask

  task automatic t_basic();
    bus_en = 1'b1; wait_n(HALF);
    do_load(8'hA5);
    run_byte(8'hA5, 8'h00, "R2 msb first pull");
  endtask

  task automatic t_peer();
    do_load(8'h3C);
    run_byte(8'h3C, 8'h81, "R3 inverted capture");
    chk("R3 rx includes peer ones", rx_last, 8'hBD);
  endtask

  task automatic t_echo();
    run_byte(8'hBD, 8'h02, "R9 echo of received byte");
    chk("R9 rx after echo", rx_last, 8'hBF);
  endtask

  task automatic t_load_busy();
    do_load(8'h12);
    for (int i = 7; i >= 4; i--) one_bit(logic'((8'h12 >> i) & 1), 1'b0, "R7 before busy load");
    do_load(8'hFF);
    for (int i = 3; i >= 0; i--) one_bit(logic'((8'h12 >> i) & 1), 1'b0, "R7 bits unchanged");
    chk("R7 rx unaffected", rx_last, 8'h12);
  endtask

  task automatic t_abort();
    int d0;
    do_load(8'hF0);
    d0 = done_cnt;
    for (int i = 0; i < 3; i++) one_bit(1'b1, 1'b0, "R6 pre abort");
    bus_en = 1'b0; wait_n(HALF);
    chk("R6 pull released on abort (wait rise)", pull, 0);
    bus_en = 1'b1; wait_n(HALF);
    do_load(8'h8F);
    bus_clk = 1'b1; wait_n(HALF);
    chk("R6 first bit driven", pull, 1);
    bus_en = 1'b0; wait_n(HALF);
    chk("R6 pull released on abort (wait fall)", pull, 0);
    bus_clk = 1'b0; wait_n(HALF);
    bus_en = 1'b1; wait_n(HALF);
    chk("R6 no done on abort", done_cnt, d0);
    do_load(8'h66);
    run_byte(8'h66, 8'h00, "R6 full byte after abort");
  endtask

  task automatic t_en_low();
    int d0 = done_cnt;
    bus_en = 1'b0; wait_n(HALF);
    for (int i = 0; i < 10; i++) begin
      bus_clk = 1'b1; wait_n(HALF);
      chk("R8 no pull while disabled", pull, 0);
      bus_clk = 1'b0; wait_n(HALF);
    end
    chk("R8 no done while disabled", done_cnt, d0);
    chk("R5 strobe one cycle", wide_err, 0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_peer();
    t_echo();
    t_load_busy();
    t_abort();
    t_en_low();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule